// File: doc/BRIEF.md
# Serial Overhead Byte Insertion Port

This block sits on the transmit side of an STS-1 frame builder. It gives external logic a bit-serial path for substituting overhead bytes. From the line clock it produces a port clock at half the line rate, where one port-clock period carries one bit. It also runs its own row, column and bit position through a 9-row by 90-column frame. Two indications go out on the falling edge of the port clock: a frame marker and an enable level. External logic uses them to find the start of transport overhead (A1 byte) and the start of path overhead (J1 byte).

External logic asks for a byte to be substituted by holding the insert strobe high and presenting the byte MSB first, one bit after each falling edge. The block samples both strobe and data on the rising edge. A byte counts only when the strobe was seen high on all eight of its bit periods. Completed bytes go to the frame builder with a one-cycle valid flag and their row and column.

A mode input decides which bytes the port serves. In path mode it serves only the J1 column, one byte per row. In transport mode it serves only the three transport columns.

Top module: `sop_ovh_port`

## Requirements
- R1: After reset the port clock output is low. It then inverts on every line-clock edge, so one bit period spans two line clocks: a low half, then a high half.
- R2: The frame output is high for exactly one bit period, twice in each frame. The first is bit 0 of row 0, column 0 (A1). The second is bit 0 of row 0, column `j1_col_i` (J1). It is low at every other bit period.
- R3: The enable output is high for all eight bit periods of every byte in column `j1_col_i`, in every row. It is low for all other bytes, including transport columns 0 to 2. So frame high with enable low marks A1, and frame high with enable high marks J1.
- R4: Frame and enable change only at the line-clock edge where the port clock falls.
- R5: Insert strobe and data are sampled only at the line-clock edge where the port clock rises. Values held only during the high half have no effect. The first bit sampled in a byte becomes bit 7 of the byte (MSB first), and eight samples form one byte.
- R6: A byte is delivered only if the strobe was sampled high on all eight bit periods. `byte_valid_o` is then high for one line clock, starting at the edge of the eighth sample, and `byte_o`, `byte_row_o` and `byte_col_o` hold the byte and its position. If the strobe drops on any bit, nothing is delivered.
- R7: With `poh_mode_i` = 1 only bytes in column `j1_col_i` are delivered. With `poh_mode_i` = 0 only bytes in columns 0 to 2 are delivered. A fully strobed byte anywhere else produces no valid pulse.
- R8: While reset is asserted, port clock, frame, enable and valid are low. The first falling port-clock edge after reset begins bit 0 of A1.
- R9: The frame has 9 rows of 90 one-byte columns, so A1 markers are 6480 bit periods apart. `j1_col_i` must lie in columns 3 to 89 and may change only at a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poh_mode_i | input | 1 | 1 = serve path overhead bytes, 0 = serve transport overhead bytes |
| j1_col_i | input | 7 | Column holding the path overhead bytes |
| ovh_data_i | input | 1 | Serial overhead data, MSB first |
| ovh_ins_i | input | 1 | Insert strobe |
| port_clk_o | output | 1 | Port clock, half the line rate |
| frame_o | output | 1 | Marker at bit 0 of A1 and of J1 |
| enable_o | output | 1 | High during path overhead bytes |
| byte_o | output | 8 | Rebuilt replacement byte |
| byte_valid_o | output | 1 | One-cycle valid for `byte_o` |
| byte_row_o | output | 4 | Row of the delivered byte |
| byte_col_o | output | 7 | Column of the delivered byte |

## Verification
A wrong position counter shows up as a misplaced frame marker or enable level within one bit period of the error, well before a full frame has passed. A bad strobe accumulator or bad shift order shows up in the next byte delivered from the served window, as a wrong value or as a valid pulse that is missing or extra. The bench drives the inverse of every bit and of the strobe during the high half of each bit period, so sampling on the wrong edge corrupts the very first substituted byte. Alternating the modes and moving J1 to the last column exposes window decoding faults within one frame.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int DEF_ROWS      = 9;
  localparam int DEF_COLS      = 90;
  localparam int DEF_TOH_COLS  = 3;
  localparam int DEF_BYTE_BITS = 8;

  typedef enum logic {
    SOP_MODE_TOH = 1'b0,
    SOP_MODE_POH = 1'b1
  } sop_mode_e;
endpackage

// File: rtl/sop_timing.sv
module sop_timing #(
  parameter int NUM_ROWS  = sop_pkg::DEF_ROWS,
  parameter int NUM_COLS  = sop_pkg::DEF_COLS,
  parameter int BYTE_BITS = sop_pkg::DEF_BYTE_BITS,
  parameter int ROW_W     = $clog2(NUM_ROWS),
  parameter int COL_W     = $clog2(NUM_COLS),
  parameter int BIT_W     = $clog2(BYTE_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             pclk_o,
  output logic             rise_ev_o,
  output logic             fall_ev_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [BIT_W-1:0] bit_o,
  output logic [ROW_W-1:0] nxt_row_o,
  output logic [COL_W-1:0] nxt_col_o,
  output logic [BIT_W-1:0] nxt_bit_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_BITS - 1);

  logic             ph_q;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    bit_d = bit_q + BIT_W'(1);
    if (bit_q == LAST_BIT) begin
      bit_d = '0;
      if (col_q == LAST_COL) begin
        col_d = '0;
        row_d = (row_q == LAST_ROW) ? '0 : row_q + ROW_W'(1);
      end else begin
        col_d = col_q + COL_W'(1);
      end
    end
  end

  // reset parks on the last bit so the first fall lands on A1 bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b0;
      row_q <= LAST_ROW;
      col_q <= LAST_COL;
      bit_q <= LAST_BIT;
    end else begin
      ph_q <= ~ph_q;
      if (ph_q) begin
        row_q <= row_d;
        col_q <= col_d;
        bit_q <= bit_d;
      end
    end
  end

  assign pclk_o    = ph_q;
  assign rise_ev_o = ~ph_q;
  assign fall_ev_o = ph_q;
  assign row_o     = row_q;
  assign col_o     = col_q;
  assign bit_o     = bit_q;
  assign nxt_row_o = row_d;
  assign nxt_col_o = col_d;
  assign nxt_bit_o = bit_d;
endmodule

// File: rtl/sop_window.sv
module sop_window #(
  parameter int TOH_COLS = sop_pkg::DEF_TOH_COLS,
  parameter int ROW_W    = 4,
  parameter int COL_W    = 7,
  parameter int BIT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_ev_i,
  input  logic             poh_mode_i,
  input  logic [COL_W-1:0] j1_col_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] nxt_row_i,
  input  logic [COL_W-1:0] nxt_col_i,
  input  logic [BIT_W-1:0] nxt_bit_i,
  output logic             served_o,
  output logic             frame_o,
  output logic             enable_o
);
  import sop_pkg::*;

  logic is_toh, is_poh;
  logic frame_q, enable_q;
  logic frame_d, enable_d;

  generate
    if (TOH_COLS == 1) begin : g_toh_single
      assign is_toh = (col_i == '0);
    end else begin : g_toh_range
      assign is_toh = (col_i < COL_W'(TOH_COLS));
    end
  endgenerate

  assign is_poh   = (col_i == j1_col_i);
  assign served_o = (sop_mode_e'(poh_mode_i) == SOP_MODE_POH) ? is_poh : is_toh;

  // lookahead on the next position so outputs move with the falling edge
  always_comb begin
    enable_d = (nxt_col_i == j1_col_i);
    frame_d  = (nxt_bit_i == '0) && (nxt_row_i == '0) &&
               ((nxt_col_i == '0) || (nxt_col_i == j1_col_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= 1'b0;
      enable_q <= 1'b0;
    end else if (fall_ev_i) begin
      frame_q  <= frame_d;
      enable_q <= enable_d;
    end
  end

  assign frame_o  = frame_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/sop_capture.sv
module sop_capture #(
  parameter int BYTE_BITS = sop_pkg::DEF_BYTE_BITS,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 7,
  parameter int BIT_W     = $clog2(BYTE_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rise_ev_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic                 served_i,
  input  logic                 data_i,
  input  logic                 ins_i,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 valid_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_BITS - 1);

  logic [BYTE_BITS-1:0] sr_q;
  logic [BYTE_BITS-1:0] byte_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic                 ok_q;
  logic                 valid_q;
  logic                 first_bit, last_bit, all_ins;

  assign first_bit = (bit_i == '0);
  assign last_bit  = (bit_i == LAST_BIT);
  assign all_ins   = (first_bit | ok_q) & ins_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      byte_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ok_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (rise_ev_i) begin
        sr_q <= {sr_q[BYTE_BITS-2:0], data_i};
        ok_q <= all_ins;
        if (last_bit && all_ins && served_i) begin
          byte_q  <= {sr_q[BYTE_BITS-2:0], data_i};
          row_q   <= row_i;
          col_q   <= col_i;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
  assign row_o   = row_q;
  assign col_o   = col_q;
endmodule

// File: rtl/sop_ovh_port.sv
module sop_ovh_port #(
  parameter int NUM_ROWS  = sop_pkg::DEF_ROWS,
  parameter int NUM_COLS  = sop_pkg::DEF_COLS,
  parameter int TOH_COLS  = sop_pkg::DEF_TOH_COLS,
  parameter int BYTE_BITS = sop_pkg::DEF_BYTE_BITS,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int BIT_W    = $clog2(BYTE_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 poh_mode_i,
  input  logic [COL_W-1:0]     j1_col_i,
  input  logic                 ovh_data_i,
  input  logic                 ovh_ins_i,
  output logic                 port_clk_o,
  output logic                 frame_o,
  output logic                 enable_o,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 byte_valid_o,
  output logic [ROW_W-1:0]     byte_row_o,
  output logic [COL_W-1:0]     byte_col_o
);
  logic             rise_ev, fall_ev, served;
  logic [ROW_W-1:0] row, nxt_row;
  logic [COL_W-1:0] col, nxt_col;
  logic [BIT_W-1:0] bitn, nxt_bit;

  sop_timing #(
    .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .BYTE_BITS(BYTE_BITS),
    .ROW_W(ROW_W), .COL_W(COL_W), .BIT_W(BIT_W)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pclk_o(port_clk_o), .rise_ev_o(rise_ev), .fall_ev_o(fall_ev),
    .row_o(row), .col_o(col), .bit_o(bitn),
    .nxt_row_o(nxt_row), .nxt_col_o(nxt_col), .nxt_bit_o(nxt_bit)
  );

  sop_window #(
    .TOH_COLS(TOH_COLS), .ROW_W(ROW_W), .COL_W(COL_W), .BIT_W(BIT_W)
  ) u_window (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_ev_i(fall_ev),
    .poh_mode_i(poh_mode_i), .j1_col_i(j1_col_i), .col_i(col),
    .nxt_row_i(nxt_row), .nxt_col_i(nxt_col), .nxt_bit_i(nxt_bit),
    .served_o(served), .frame_o(frame_o), .enable_o(enable_o)
  );

  sop_capture #(
    .BYTE_BITS(BYTE_BITS), .ROW_W(ROW_W), .COL_W(COL_W), .BIT_W(BIT_W)
  ) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_ev_i(rise_ev),
    .bit_i(bitn), .row_i(row), .col_i(col), .served_i(served),
    .data_i(ovh_data_i), .ins_i(ovh_ins_i),
    .byte_o(byte_o), .valid_o(byte_valid_o),
    .row_o(byte_row_o), .col_o(byte_col_o)
  );
endmodule

// File: rtl/sop_ovh_port_chk.sv
module sop_ovh_port_chk #(
  parameter int TOH_COLS = sop_pkg::DEF_TOH_COLS,
  parameter int COL_W    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             poh_mode_i,
  input logic [COL_W-1:0] j1_col_i,
  input logic             port_clk_o,
  input logic             frame_o,
  input logic             enable_o,
  input logic             byte_valid_o,
  input logic [COL_W-1:0] byte_col_o
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  AST_PCLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    port_clk_o != $past(port_clk_o)); // R1
  AST_FRAME_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    $rose(frame_o) |=> frame_o); // R2
  AST_FRAME_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    !$stable(frame_o) |-> $fell(port_clk_o)); // R4
  AST_ENABLE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    !$stable(enable_o) |-> $fell(port_clk_o)); // R4
  AST_VALID_HIGH_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    byte_valid_o |-> port_clk_o); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    byte_valid_o |=> !byte_valid_o); // R6
  AST_VALID_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni || !started_q)
    byte_valid_o |-> (poh_mode_i ? (byte_col_o == j1_col_i)
                                 : (byte_col_o < COL_W'(TOH_COLS)))); // R7
endmodule

bind sop_ovh_port sop_ovh_port_chk #(.TOH_COLS(TOH_COLS), .COL_W(COL_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .poh_mode_i(poh_mode_i), .j1_col_i(j1_col_i),
  .port_clk_o(port_clk_o), .frame_o(frame_o), .enable_o(enable_o),
  .byte_valid_o(byte_valid_o), .byte_col_o(byte_col_o)
);

// File: tb/sop_ovh_port_tb.sv
module sop_ovh_port_tb_top;
  localparam int ROWS = 9;
  localparam int COLS = 90;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       poh_mode_i = 1'b0;
  logic [6:0] j1_col_i = 7'd10;
  logic       ovh_data_i = 1'b0;
  logic       ovh_ins_i = 1'b0;
  logic       port_clk_o, frame_o, enable_o, byte_valid_o;
  logic [7:0] byte_o;
  logic [3:0] byte_row_o;
  logic [6:0] byte_col_o;

  typedef struct packed {
    logic [7:0] val;
    logic [6:0] col;
    logic [3:0] row;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;

  always #10 clk_i = ~clk_i;

  sop_ovh_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .poh_mode_i(poh_mode_i), .j1_col_i(j1_col_i),
    .ovh_data_i(ovh_data_i), .ovh_ins_i(ovh_ins_i),
    .port_clk_o(port_clk_o), .frame_o(frame_o), .enable_o(enable_o),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .byte_row_o(byte_row_o), .byte_col_o(byte_col_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // insertion plan per byte
  function automatic void plan(input int f, input int r, input int c, input int j1,
                               output bit ins, output bit part, output logic [7:0] v);
    v    = 8'((r * 31 + c * 7 + f * 13) & 255) ^ 8'hA5;
    ins  = (c < 3) || (c == j1) || (c == 50);
    if (f == 2 && c < 3 && (r % 2) == 1) ins = 1'b0;
    part = ins && ((r == 4 && c == 1) || (r == 6 && c == j1));
  endfunction

  // monitor: pops expected bytes as the design delivers them
  always @(negedge clk_i) begin
    if (rst_ni && byte_valid_o) begin
      chk(port_clk_o == 1'b1, "R6 valid in high half", port_clk_o, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected delivery col", byte_col_o, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(byte_o == e.val, "R5 byte value", byte_o, e.val);
        chk(byte_row_o == e.row, "R6 byte row", byte_row_o, e.row);
        chk(byte_col_o == e.col, "R6 byte col", byte_col_o, e.col);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int b_row = ROWS - 1;
    int b_col = COLS - 1;
    int b_bit = 7;
    int frame_no = -1;
    int cur_j1 = 10;
    bit prev_pclk = 0;
    bit prev_frame = 0;
    bit prev_en = 0;
    bit cur_ins = 0;
    bit cur_part = 0;
    logic [7:0] cur_val = '0;
    bit drv_d = 0;
    bit drv_i = 0;
    bit first_fall = 1;

    repeat (3) @(negedge clk_i);
    chk(port_clk_o == 0, "R8 reset port clock", port_clk_o, 0);
    chk(frame_o == 0, "R8 reset frame", frame_o, 0);
    chk(enable_o == 0, "R8 reset enable", enable_o, 0);
    chk(byte_valid_o == 0, "R8 reset valid", byte_valid_o, 0);
    rst_ni = 1'b1;

    while (!done) begin
      @(negedge clk_i);
      chk(port_clk_o != prev_pclk, "R1 port clock toggle", port_clk_o, !prev_pclk);
      if (prev_pclk && !port_clk_o) begin
        b_bit++;
        if (b_bit == 8) begin
          b_bit = 0;
          b_col++;
          if (b_col == COLS) begin
            b_col = 0;
            b_row++;
            if (b_row == ROWS) begin
              b_row = 0;
              frame_no++;
              if (frame_no >= 4) done = 1;
              else begin
                cur_j1 = (frame_no < 2) ? 10 : COLS - 1;
                j1_col_i = 7'(cur_j1);
                poh_mode_i = (frame_no % 2) == 1;
              end
            end
          end
        end
        if (first_fall) begin
          chk(frame_o && !enable_o, "R8 first fall is A1", {frame_o, enable_o}, 2);
          first_fall = 0;
        end
        if (b_bit == 0 && b_row == 0 && b_col == 0)
          chk(frame_o == 1, "R9 A1 marker spacing", frame_o, 1);
        chk(frame_o == (b_bit == 0 && b_row == 0 && (b_col == 0 || b_col == cur_j1)),
            "R2 frame marker", frame_o,
            (b_bit == 0 && b_row == 0 && (b_col == 0 || b_col == cur_j1)));
        chk(enable_o == (b_col == cur_j1), "R3 enable window", enable_o, b_col == cur_j1);
        if (done) begin
          ovh_ins_i = 1'b0;
        end else begin
          if (b_bit == 0) begin
            plan(frame_no, b_row, b_col, cur_j1, cur_ins, cur_part, cur_val);
            if (cur_ins && !cur_part &&
                (poh_mode_i ? (b_col == cur_j1) : (b_col < 3))) begin
              exp_t e;
              e.val = cur_val;
              e.col = 7'(b_col);
              e.row = 4'(b_row);
              exp_q.push_back(e);
            end
          end
          drv_d = cur_val[7 - b_bit];
          drv_i = cur_ins && !(cur_part && b_bit == 5);
          ovh_data_i = drv_d;
          ovh_ins_i  = drv_i;
        end
      end else begin
        chk(frame_o == prev_frame, "R4 frame held at rise", frame_o, prev_frame);
        chk(enable_o == prev_en, "R4 enable held at rise", enable_o, prev_en);
        // inverted data and strobe in the high half must be ignored (R5)
        ovh_data_i = ~drv_d;
        ovh_ins_i  = done ? 1'b0 : ~drv_i;
      end
      prev_pclk  = port_clk_o;
      prev_frame = frame_o;
      prev_en    = enable_o;
    end

    repeat (40) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 all expected bytes delivered", exp_q.size(), 0);
    finish_run();
  end
endmodule